// File: doc/BRIEF.md
# Serial Clock Baud Generator

This block derives the timing of a serial clock (SCK) from the module input clock for two independent directions, transmit and receive. Each direction has its own 16-bit clock-select register. The register holds a 5-bit prescale value and a 3-bit divider code. The overall division ratio is the prescale value times the divider picked by the code. For each direction the block produces a one-cycle half-period strobe and a phase bit. A frame serializer uses the strobe to toggle SCK and to shift or sample data. It uses the phase bit to tell the leading half of a period from the trailing half.

A direction counts only while its enable input is high. When the enable is low, its counter, strobe and phase are held cleared. Raising the enable therefore always starts from the idle phase, and the first strobe comes one full half period later. Software or a sequencer loads the registers through a plain write port while the direction is idle. Choosing a setting for a target bit rate is left to the caller.

Top module: `sck_baud_gen`

## Requirements
- R1: While reset is asserted, every strobe and phase output is 0. Both clock-select registers reset to 0, which is prescale 1 and divide-by-2 (ratio 2), so the strobe is then high every enabled cycle.
- R2: The prescale value is the register field at bits 12:8 plus one, giving 1 to 32.
- R3: The divider code at bits 2:0 selects divide by 2, 4, 8, 16 or 32 for codes 0, 1, 2, 3 and 4. Code 7 bypasses the divider (divide by 1). The overall ratio N is prescale times divider, up to 1024.
- R4: Codes 5 and 6 are reserved and divide by 1, the same as code 7.
- R5: The half period H is floor(N/2), with a minimum of 1. While enabled, the strobe is high for one cycle every H input cycles, or on every cycle when H is 1.
- R6: Counting the rising clock edges that sample the enable high as 1, 2, 3 and so on, the strobe is high after edge k exactly when k is a multiple of H. The first strobe follows edge H.
- R7: A clock edge that samples the enable low clears the counter, the strobe and the phase of that direction.
- R8: The phase output is 0 when idle and inverts in each cycle in which the strobe is high. After edge k its value is (k/H) mod 2.
- R9: Register bits 15:13 and 7:3 are ignored.
- R10: A write with cfg_sel 0 loads the transmit register and a write with cfg_sel 1 loads the receive register. A write to one leaves the other unchanged. A write takes effect from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 transmit, 1 receive |
| cfg_wdata | input | 16 | Clock-select write data |
| tx_en | input | 1 | Transmit timing enable |
| rx_en | input | 1 | Receive timing enable |
| tx_half_stb | output | 1 | Transmit half-period strobe |
| tx_phase | output | 1 | Transmit half-period phase |
| rx_half_stb | output | 1 | Receive half-period strobe |
| rx_phase | output | 1 | Receive half-period phase |

## Verification
The bench goes after these corner cases:
- The largest ratio (32 × 32), where a counter one bit short would wrap and strobe far too early.
- Ratio 1 and ratio 2, which must both give a strobe on every cycle. A decoder without the minimum of 1 would stall here.
- An odd total ratio, where rounding up instead of down shifts every strobe by one cycle.
- The reserved codes. Treating them as another divide-by-2^n would stretch the period.
- Garbage in the unused register bits, and a write to one direction while the other keeps its setting. An address-decode or field-slice error would change the cadence of the wrong channel.
- A disable in the middle of an odd phase followed by a re-enable. A generator that did not clear would strobe early or start on the wrong phase.

// File: rtl/sck_baud_pkg.sv
`timescale 1ns/1ps
package sck_baud_pkg;
  localparam int CSR_W        = 16;
  localparam int PRE_LSB      = 8;
  localparam int PRE_W        = 5;
  localparam int CODE_LSB     = 0;
  localparam int CODE_W       = 3;
  localparam int MAX_DIV_LOG2 = 5;
  localparam int RATIO_W      = PRE_W + MAX_DIV_LOG2 + 1;
  localparam int HALF_W       = RATIO_W - 1;
  localparam int NUM_CH       = 2;

  typedef struct packed {
    logic [PRE_W-1:0]  pre_m1;
    logic [CODE_W-1:0] code;
  } clk_sel_t;
endpackage

// File: rtl/sck_baud_csr.sv
`timescale 1ns/1ps
module sck_baud_csr
  import sck_baud_pkg::*;
#(
  parameter int CH    = NUM_CH,
  parameter int SEL_W = (CH > 1) ? $clog2(CH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [SEL_W-1:0]      sel,
  input  logic [CSR_W-1:0]      wdata,
  output clk_sel_t [CH-1:0]     cfg_q
);
  for (genvar ch = 0; ch < CH; ch++) begin : g_reg
    clk_sel_t r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r <= '0;
      end else if (we && sel == SEL_W'(ch)) begin
        r.pre_m1 <= wdata[PRE_LSB +: PRE_W];
        r.code   <= wdata[CODE_LSB +: CODE_W];
      end
    end
    assign cfg_q[ch] = r;
  end
endmodule

// File: rtl/sck_baud_ratio_dec.sv
`timescale 1ns/1ps
module sck_baud_ratio_dec #(
  parameter int PRE_W        = 5,
  parameter int CODE_W       = 3,
  parameter int MAX_DIV_LOG2 = 5,
  localparam int RATIO_W     = PRE_W + MAX_DIV_LOG2 + 1,
  localparam int HALF_W      = RATIO_W - 1,
  localparam int SH_W        = $clog2(MAX_DIV_LOG2 + 2)
) (
  input  logic [PRE_W-1:0]  pre_m1,
  input  logic [CODE_W-1:0] code,
  output logic [HALF_W-1:0] half_len
);
  logic [RATIO_W-1:0] pre_val;
  logic [RATIO_W-1:0] ratio;
  logic [SH_W-1:0]    shamt;

  always_comb begin
    pre_val = RATIO_W'(pre_m1) + RATIO_W'(1);
    // Codes 0..MAX_DIV_LOG2-1 select a power-of-two divider; all others bypass.
    if (code <= CODE_W'(MAX_DIV_LOG2 - 1)) shamt = SH_W'(code) + SH_W'(1);
    else                                   shamt = '0;
    ratio    = pre_val << shamt;
    half_len = ratio[RATIO_W-1:1];
    if (half_len == '0) half_len = HALF_W'(1);
  end
endmodule

// File: rtl/sck_baud_half_timer.sv
`timescale 1ns/1ps
module sck_baud_half_timer #(
  parameter int HALF_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [HALF_W-1:0] half_len,
  output logic              stb,
  output logic              phase
);
  logic [HALF_W-1:0] cnt;
  logic              term;

  assign term = (cnt >= half_len - HALF_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      stb   <= 1'b0;
      phase <= 1'b0;
    end else if (!en) begin
      cnt   <= '0;
      stb   <= 1'b0;
      phase <= 1'b0;
    end else if (term) begin
      cnt   <= '0;
      stb   <= 1'b1;
      phase <= ~phase;
    end else begin
      cnt   <= cnt + HALF_W'(1);
      stb   <= 1'b0;
    end
  end
endmodule

// File: rtl/sck_baud_gen.sv
`timescale 1ns/1ps
module sck_baud_gen
  import sck_baud_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [CSR_W-1:0] cfg_wdata,
  input  logic             tx_en,
  input  logic             rx_en,
  output logic             tx_half_stb,
  output logic             tx_phase,
  output logic             rx_half_stb,
  output logic             rx_phase
);
  clk_sel_t [NUM_CH-1:0] cfg;
  logic     [NUM_CH-1:0] en_v;
  logic     [NUM_CH-1:0] stb_v;
  logic     [NUM_CH-1:0] ph_v;

  assign en_v = {rx_en, tx_en};

  sck_baud_csr #(.CH(NUM_CH), .SEL_W(1)) u_csr (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .sel   (cfg_sel),
    .wdata (cfg_wdata),
    .cfg_q (cfg)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [HALF_W-1:0] half_len;

    sck_baud_ratio_dec #(
      .PRE_W(PRE_W), .CODE_W(CODE_W), .MAX_DIV_LOG2(MAX_DIV_LOG2)
    ) u_dec (
      .pre_m1   (cfg[ch].pre_m1),
      .code     (cfg[ch].code),
      .half_len (half_len)
    );

    sck_baud_half_timer #(.HALF_W(HALF_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en_v[ch]),
      .half_len (half_len),
      .stb      (stb_v[ch]),
      .phase    (ph_v[ch])
    );
  end

  assign tx_half_stb = stb_v[0];
  assign tx_phase    = ph_v[0];
  assign rx_half_stb = stb_v[1];
  assign rx_phase    = ph_v[1];
endmodule

// File: rtl/sck_baud_gen_chk.sv
`timescale 1ns/1ps
module sck_baud_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic rx_en,
  input logic tx_half_stb,
  input logic tx_phase,
  input logic rx_half_stb,
  input logic rx_phase
);
  // R7
  tx_idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tx_en) |-> (!tx_half_stb && !tx_phase));

  // R7
  rx_idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rx_en) |-> (!rx_half_stb && !rx_phase));

  // R8
  tx_phase_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tx_en) |-> ((tx_phase != $past(tx_phase)) == tx_half_stb));

  // R8
  rx_phase_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rx_en) |-> ((rx_phase != $past(rx_phase)) == rx_half_stb));

  // R6
  tx_stb_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_half_stb |-> $past(tx_en));

  // R6
  rx_stb_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_half_stb |-> $past(rx_en));
endmodule

bind sck_baud_gen sck_baud_gen_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .tx_en       (tx_en),
  .rx_en       (rx_en),
  .tx_half_stb (tx_half_stb),
  .tx_phase    (tx_phase),
  .rx_half_stb (rx_half_stb),
  .rx_phase    (rx_phase)
);

// File: tb/sck_baud_gen_tb_top.sv
`timescale 1ns/1ps
module sck_baud_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        tx_en = 1'b0;
  logic        rx_en = 1'b0;
  logic        tx_half_stb, tx_phase, rx_half_stb, rx_phase;

  always #5 clk = ~clk;

  sck_baud_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .tx_en(tx_en), .rx_en(rx_en),
    .tx_half_stb(tx_half_stb), .tx_phase(tx_phase),
    .rx_half_stb(rx_half_stb), .rx_phase(rx_phase)
  );

  typedef struct packed { logic stb; logic ph; } exp_t;
  exp_t  q_tx[$];
  exp_t  q_rx[$];
  string t_tx[$];
  string t_rx[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    finished = 1'b0;

  function automatic int half_of(int p, int code);
    int d;
    d = (code <= 4) ? (2 << code) : 1;
    half_of = (p * d) / 2;
    if (half_of < 1) half_of = 1;
  endfunction

  task automatic cmp(string tag, string ch, logic [1:0] got, logic [1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s {stb,phase}: got %b expected %b at %0t", tag, ch, got, exp, $time);
    end
  endtask

  task automatic write_cfg(logic s, logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drain();
    while (q_tx.size() > 0 || q_rx.size() > 0) @(negedge clk);
  endtask

  // Driver: enable both channels, push the expected per-cycle outputs, then disable.
  task automatic run(int htx, int hrx, int cycles, string tag);
    @(negedge clk);
    tx_en = 1'b1; rx_en = 1'b1;
    @(posedge clk);
    for (int k = 1; k <= cycles; k++) begin
      q_tx.push_back(exp_t'({1'((k % htx) == 0), 1'((k / htx) % 2)}));
      q_rx.push_back(exp_t'({1'((k % hrx) == 0), 1'((k / hrx) % 2)}));
      t_tx.push_back(tag);
      t_rx.push_back(tag);
    end
    drain();
    @(negedge clk);
    tx_en = 1'b0; rx_en = 1'b0;
    @(posedge clk);
    for (int k = 0; k < 3; k++) begin
      q_tx.push_back('0); q_rx.push_back('0);
      t_tx.push_back("R7 disable clears"); t_rx.push_back("R7 disable clears");
    end
    drain();
  endtask

  // Monitor: pop and compare one expected item per cycle, away from the edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q_tx.size() > 0) cmp(t_tx.pop_front(), "tx", {tx_half_stb, tx_phase}, q_tx.pop_front());
      if (q_rx.size() > 0) cmp(t_rx.pop_front(), "rx", {rx_half_stb, rx_phase}, q_rx.pop_front());
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp("R1 reset", "tx", {tx_half_stb, tx_phase}, 2'b00);
    cmp("R1 reset", "rx", {rx_half_stb, rx_phase}, 2'b00);
    rst_n = 1'b1;

    // R1 defaults: ratio 2, H=1
    run(1, 1, 8, "R1 default ratio");

    // R2 R3: tx P=3 code0 (N=6,H=3), rx P=1 code1 (N=4,H=2)
    write_cfg(1'b0, 16'h0200);
    write_cfg(1'b1, 16'h0001);
    run(half_of(3, 0), half_of(1, 1), 20, "R2 R3 R5 R6 R8 basic");

    // R3: tx P=1 code4 (N=32), rx P=1 code2 (N=8)
    write_cfg(1'b0, 16'h0004);
    write_cfg(1'b1, 16'h0002);
    run(half_of(1, 4), half_of(1, 2), 40, "R3 code4 code2");

    // R3 R5: maximum 32x32 on tx, bypass ratio 1 on rx
    write_cfg(1'b0, 16'h1F04);
    write_cfg(1'b1, 16'h0007);
    run(half_of(32, 4), half_of(1, 7), 1100, "R3 R5 max ratio and ratio 1");

    // R4 R5: reserved codes, odd ratio; end mid odd phase for R6/R7 restart
    write_cfg(1'b0, 16'h0505);
    write_cfg(1'b1, 16'h0406);
    run(half_of(6, 5), half_of(5, 6), 11, "R4 R5 reserved codes");
    run(half_of(6, 5), half_of(5, 6), 7, "R6 restart from idle");

    // R9: junk in ignored bits; tx P=3 code1, rx P=32 code7
    write_cfg(1'b0, 16'hA2A9);
    write_cfg(1'b1, 16'hFFFF);
    run(half_of(3, 1), half_of(32, 7), 40, "R9 ignored bits");

    // R10: write tx only; rx keeps P=32 code7
    write_cfg(1'b0, 16'h0100);
    run(half_of(2, 0), half_of(32, 7), 40, "R10 separate registers");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule